// File: doc/BRIEF.md
# Multichip Sync Receiver with Presettable Clock-State Counter

This block aligns the internal clock-state counter of one device to a shared, periodic sync input so that several identical devices can run with matching or deliberately offset counter phases. The raw sync input is brought into the local system-clock domain through a synchronizer chain. Each rising edge is detected there and turned into a strobe that lasts one clock cycle.

The strobe loads a per-device preset word into a free-running 6-bit clock-state counter. The counter then carries on stepping by one per cycle from that value. If two devices see the same edge-aligned sync input and hold the same preset word, their counters match. If they hold different preset words, their counters keep a fixed difference.

A timing check measures the interval between successive detected edges. It raises a sticky flag when an interval differs from the one before it. A control input turns this check off. A separate enable input blocks the sync path completely.

Top module: `msync_rx`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 0, `sync_pulse_o` is 0 and `samp_err_o` is 0.
- R2: When no sync pulse was high in the previous cycle, `state_o` advances by one every clock cycle modulo 64, so 63 is followed by 0.
- R3: Each rising edge of `sync_raw_i` gives exactly one `sync_pulse_o` lasting one cycle. A sync input that stays high gives no further pulses, and a periodic input gives one pulse per period.
- R4: When `sync_raw_i` goes from 0 to 1 between two clock edges, `sync_pulse_o` is high after the third rising clock edge that follows. The delay is two synchronizer stages plus one pulse register.
- R5: In the cycle after `sync_pulse_o` is high, `state_o` equals `preset_i`, including 63. It then continues counting from that value.
- R6: While `rx_enable_i` is 0, no sync pulse is issued and the counter runs freely.
- R7: `samp_err_o` goes high together with the pulse of an edge whose interval from the previous edge differs from the interval before that. A constant period never raises it, and the first two edges after reset, enable or re-validation are never compared.
- R8: Once high, `samp_err_o` stays high until reset while validation is enabled, even if the period becomes regular again.
- R9: While `val_disable_i` is 1, `samp_err_o` is 0 from the next cycle on. Interval history is discarded, so the first two edges after the control is released are not compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sync_raw_i | input | 1 | Raw periodic sync input, asynchronous to clk_i |
| preset_i | input | 6 | Counter value loaded by a sync pulse |
| rx_enable_i | input | 1 | 1 lets detected edges produce pulses |
| val_disable_i | input | 1 | 1 turns interval validation off and clears the error |
| state_o | output | 6 | Clock-state counter |
| sync_pulse_o | output | 1 | One-cycle strobe per detected rising edge |
| samp_err_o | output | 1 | Sticky sync-interval error flag |

## Verification
A corrupted counter register shows up on `state_o` in the very next cycle, because every cycle's value is predicted from the one before or from the preset after a pulse. A stale edge-history flop shows up as a missing or doubled pulse within three cycles of an input edge. A wrong interval store in the validator stays hidden until the following edge, so it appears on `samp_err_o` one sync period later. Mismatched periods and released validation are therefore driven for several periods each.

// File: rtl/msync_pkg.sv
package msync_pkg;
    localparam int unsigned STATE_W_DEF = 6;
    localparam int unsigned GAP_W_DEF   = 12;
    localparam int unsigned STAGES_DEF  = 2;

    // How many edges have been seen since history was last cleared
    typedef enum logic [1:0] {
        SEEN_NONE = 2'd0,
        SEEN_ONE  = 2'd1,
        SEEN_TWO  = 2'd2
    } seen_e;
endpackage

// File: rtl/msync_sync2.sv
module msync_sync2 #(
    parameter int unsigned STAGES = msync_pkg::STAGES_DEF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.chain[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            r_d.chain[i] = r_q.chain[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign sync_o = r_q.chain[STAGES-1];
endmodule

// File: rtl/msync_edge.sv
module msync_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sync_i,
    input  logic enable_i,
    output logic rise_o,
    output logic pulse_o
);
    typedef struct packed {
        logic prev;
        logic pulse;
    } edge_regs_t;

    edge_regs_t r_d, r_q;
    logic       rise;

    always_comb begin
        rise        = sync_i & ~r_q.prev & enable_i;
        r_d         = r_q;
        r_d.prev    = sync_i;
        r_d.pulse   = rise;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign rise_o  = rise;
    assign pulse_o = r_q.pulse;

    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.pulse |=> !r_q.pulse); // R3
    AST_NO_PULSE_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> !r_q.pulse); // R6
endmodule

// File: rtl/msync_gap_chk.sv
module msync_gap_chk #(
    parameter int unsigned GAP_W = msync_pkg::GAP_W_DEF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,
    input  logic enable_i,
    input  logic val_disable_i,
    output logic err_o
);
    import msync_pkg::*;

    localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic [GAP_W-1:0] last;
        seen_e            seen;
        logic             err;
    } gap_regs_t;

    gap_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.gap = (r_q.gap == GAP_MAX) ? r_q.gap : r_q.gap + 1'b1;
        if (val_disable_i) begin
            r_d.seen = SEEN_NONE;
            r_d.err  = 1'b0;
        end else if (!enable_i) begin
            r_d.seen = SEEN_NONE;
        end else if (rise_i) begin
            r_d.gap  = '0;
            r_d.last = r_q.gap;
            if (r_q.seen == SEEN_TWO && r_q.gap != r_q.last) begin
                r_d.err = 1'b1;
            end
            case (r_q.seen)
                SEEN_NONE: r_d.seen = SEEN_ONE;
                default:   r_d.seen = SEEN_TWO;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '{gap: '0, last: '0, seen: SEEN_NONE, err: 1'b0};
        else         r_q <= r_d;
    end

    assign err_o = r_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.err && !val_disable_i) |=> r_q.err); // R8
    AST_ERR_OFF_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        val_disable_i |=> !r_q.err); // R9
    AST_ERR_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!r_q.err && !rise_i) |=> !r_q.err); // R7
endmodule

// File: rtl/msync_state_cnt.sv
module msync_state_cnt #(
    parameter int unsigned STATE_W = msync_pkg::STATE_W_DEF
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_i,
    input  logic [STATE_W-1:0] preset_i,
    output logic [STATE_W-1:0] state_o
);
    typedef struct packed {
        logic [STATE_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) r_d.cnt = preset_i;
        else        r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign state_o = r_q.cnt;

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> r_q.cnt == STATE_W'($past(r_q.cnt) + 1'b1)); // R2
    AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> r_q.cnt == $past(preset_i)); // R5
endmodule

// File: rtl/msync_rx.sv
module msync_rx #(
    parameter int unsigned STATE_W = msync_pkg::STATE_W_DEF,
    parameter int unsigned GAP_W   = msync_pkg::GAP_W_DEF,
    parameter int unsigned STAGES  = msync_pkg::STAGES_DEF
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sync_raw_i,
    input  logic [STATE_W-1:0] preset_i,
    input  logic               rx_enable_i,
    input  logic               val_disable_i,
    output logic [STATE_W-1:0] state_o,
    output logic               sync_pulse_o,
    output logic               samp_err_o
);
    logic sync_s;
    logic rise;
    logic pulse;

    msync_sync2 #(.STAGES(STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (sync_raw_i),
        .sync_o  (sync_s)
    );

    msync_edge u_edge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sync_i   (sync_s),
        .enable_i (rx_enable_i),
        .rise_o   (rise),
        .pulse_o  (pulse)
    );

    msync_gap_chk #(.GAP_W(GAP_W)) u_gap (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .rise_i        (rise),
        .enable_i      (rx_enable_i),
        .val_disable_i (val_disable_i),
        .err_o         (samp_err_o)
    );

    msync_state_cnt #(.STATE_W(STATE_W)) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (pulse),
        .preset_i (preset_i),
        .state_o  (state_o)
    );

    assign sync_pulse_o = pulse;

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |=> (!rst_ni || (state_o == '0 && !sync_pulse_o && !samp_err_o))); // R1
endmodule

// File: tb/msync_rx_tb.sv
`timescale 1ns/1ps
module msync_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_raw = 1'b0;
    logic [5:0] preset = 6'd0;
    logic       rx_en = 1'b1;
    logic       vdis = 1'b0;
    logic [5:0] state;
    logic       pulse;
    logic       err;

    int   n_vec = 0;
    int   n_bad = 0;
    int   pulses = 0;
    logic last_pulse = 1'b0;
    logic [5:0] prev_state = 6'd0;
    logic have_prev = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    msync_rx dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .sync_raw_i    (sync_raw),
        .preset_i      (preset),
        .rx_enable_i   (rx_en),
        .val_disable_i (vdis),
        .state_o       (state),
        .sync_pulse_o  (pulse),
        .samp_err_o    (err)
    );

    task automatic chk(input logic ok, input string req, input int got, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // One cycle: sample at the falling edge, check the counter, then drive the sync input
    task automatic tick(input logic raw);
        logic [5:0] exp;
        @(negedge clk);
        if (have_prev) begin
            if (last_pulse) begin
                exp = preset;
                chk(state == exp, "R5", state, exp);
            end else begin
                exp = prev_state + 6'd1;
                chk(state == exp, "R2", state, exp);
            end
        end
        if (pulse) pulses++;
        last_pulse = pulse;
        prev_state = state;
        have_prev  = 1'b1;
        sync_raw   = raw;
    endtask

    task automatic run_periods(input int p, input int n);
        for (int k = 0; k < n; k++)
            for (int i = 0; i < p; i++)
                tick(i < p / 2);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sync_raw = 1'b0;
        repeat (3) @(negedge clk);
        chk(state == 6'd0, "R1", state, 0);
        chk(pulse == 1'b0, "R1", pulse, 0);
        chk(err == 1'b0, "R1", err, 0);
        rst_n = 1'b1;
        have_prev  = 1'b0;
        last_pulse = 1'b0;
        pulses = 0;
    endtask

    task automatic t_reset_and_count();
        rx_en = 1'b1; vdis = 1'b0;
        do_reset();
        for (int i = 0; i < 70; i++) tick(1'b0);  // passes the 63 -> 0 wrap
        chk(pulses == 0, "R2", pulses, 0);
    endtask

    task automatic t_latency_and_level();
        preset = 6'd37;
        do_reset();
        repeat (5) tick(1'b0);
        tick(1'b1);
        tick(1'b1); chk(pulse == 1'b0, "R4", pulse, 0);
        tick(1'b1); chk(pulse == 1'b0, "R4", pulse, 0);
        tick(1'b1); chk(pulse == 1'b1, "R4", pulse, 1);
        tick(1'b1); chk(pulse == 1'b0, "R3", pulse, 0);
        chk(state == 6'd37, "R5", state, 37);
        for (int i = 0; i < 20; i++) tick(1'b1);
        chk(pulses == 1, "R3", pulses, 1);
    endtask

    task automatic t_periodic_wrap();
        preset = 6'd63;
        do_reset();
        repeat (4) tick(1'b0);
        run_periods(8, 6);
        chk(pulses == 6, "R3", pulses, 6);
        chk(err == 1'b0, "R7", err, 0);
    endtask

    task automatic t_error_sticky();
        preset = 6'd5;
        do_reset();
        repeat (4) tick(1'b0);
        run_periods(8, 4);
        chk(err == 1'b0, "R7", err, 0);
        run_periods(12, 2);
        chk(err == 1'b1, "R7", err, 1);
        run_periods(8, 4);
        chk(err == 1'b1, "R8", err, 1);
        vdis = 1'b1;
        tick(1'b0);
        tick(1'b0);
        chk(err == 1'b0, "R9", err, 0);
        vdis = 1'b0;
    endtask

    task automatic t_validation_off();
        preset = 6'd20;
        do_reset();
        vdis = 1'b1;
        repeat (4) tick(1'b0);
        run_periods(8, 2);
        run_periods(14, 2);
        run_periods(6, 3);
        chk(err == 1'b0, "R9", err, 0);
        vdis = 1'b0;
        run_periods(10, 4);
        chk(err == 1'b0, "R9", err, 0);
        chk(pulses == 11, "R3", pulses, 11);
    endtask

    task automatic t_rx_disabled();
        preset = 6'd9;
        do_reset();
        rx_en = 1'b0;
        repeat (4) tick(1'b0);
        run_periods(8, 4);
        chk(pulses == 0, "R6", pulses, 0);
        chk(err == 1'b0, "R6", err, 0);
        rx_en = 1'b1;
        run_periods(8, 3);
        chk(pulses == 3, "R6", pulses, 3);
        chk(err == 1'b0, "R7", err, 0);
    endtask

    initial begin
        t_reset_and_count();
        t_latency_and_level();
        t_periodic_wrap();
        t_error_sticky();
        t_validation_off();
        t_rx_disabled();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(5ns * 20000);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule